// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block settles how an asynchronous processor bus cycle ends. Three active-low control lines come from the outside world: data acknowledge, bus error and halt. The controller passes them through a synchronizer and samples them whenever the bus state sequencer marks an even bus state. The first even state at which acknowledge or error is seen is called state N. The cycle is resolved at the following even state, N+2.

The outcome is one of four: normal completion, completion followed by a stop, a bus error trap, or a retry. It appears as a one-clock pulse on exactly one of four outputs. After a stop or a retry, a stall output holds the processor until halt is released. A retry then ends with a single request to re-run the same cycle. Acknowledge or error arriving only at N+2, after a clean acknowledge at N, does not change the result. Error together with halt means retry, not trap.

Top module: `bus_term_ctrl`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, the outputs normal_o, halted_o, bus_err_o, retry_o, stall_o and retry_req_o are all low, and the controller is idle.
- R2: If acknowledge is seen at state N with error and halt negated, normal_o pulses at the N+2 sample and stall_o stays low.
- R3: If acknowledge and halt are seen at state N with error negated, halted_o pulses at the N+2 sample. stall_o then stays high until the synchronized halt is seen negated, and no retry request follows.
- R4: If error is seen at state N with halt negated, bus_err_o pulses at the N+2 sample, whether or not acknowledge is also asserted. stall_o stays low.
- R5: If error and halt are both seen at state N, retry_o pulses at the N+2 sample and stall_o stays high while halt stays asserted. retry_req_o pulses once, for one clock, on the edge where stall_o falls after halt is seen negated.
- R6: Once acknowledge alone is seen at state N, error or error-plus-halt that first appears at N+2 is ignored and the outcome is normal_o.
- R7: An even-state sample with neither acknowledge nor error asserted adds a wait state: no outcome is produced and the next even state is sampled again. Halt alone does not end a cycle.
- R8: At most one of normal_o, halted_o, bus_err_o and retry_o is high in any cycle, and each pulse lasts exactly one clock.
- R9: Each control input passes through SYNC_STAGES (default 2) flops. A pin change made one clock before an even-state strobe is not seen by that strobe.
- R10: even_state_i is ignored while idle, and cyc_start_i is ignored while a cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_start_i | input | 1 | One-clock strobe: a bus cycle begins |
| even_state_i | input | 1 | One-clock strobe on each even bus state (a sampling point) |
| dtack_ni | input | 1 | Data acknowledge, active low, asynchronous |
| berr_ni | input | 1 | Bus error, active low, asynchronous |
| halt_ni | input | 1 | Halt, active low, asynchronous |
| normal_o | output | 1 | Pulse: cycle ended normally |
| halted_o | output | 1 | Pulse: cycle ended, processor stops until halt is released |
| bus_err_o | output | 1 | Pulse: cycle terminated, bus error trap requested |
| retry_o | output | 1 | Pulse: cycle terminated, to be re-run after halt is released |
| stall_o | output | 1 | Processor held while halt remains asserted |
| retry_req_o | output | 1 | One-clock request to restart the same cycle |

## Verification
On every cycle the assertions check several properties. The four outcome pulses are mutually exclusive and each lasts one clock. An outcome appears only right after an even-state strobe. A halted or retry outcome raises stall, while a normal or error outcome never does. A retry request appears only as stall falls. Which outcome a given arrival order of acknowledge, error and halt produces cannot be seen by a property; only the bench scenarios show it. The same holds for the late error being ignored, wait states under halt alone, synchronizer latency, and ignored strobes, all of which are compared against the bench's cycle model.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;
  typedef enum logic [1:0] {
    OUT_NORMAL = 2'd0,
    OUT_HALTED = 2'd1,
    OUT_BERR   = 2'd2,
    OUT_RETRY  = 2'd3
  } outcome_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT    = 2'd1,
    ST_CONFIRM = 2'd2,
    ST_HOLD    = 2'd3
  } state_e;

  // synchronized controls, active high
  typedef struct packed {
    logic ack;
    logic err;
    logic hlt;
  } ctl_t;

  localparam int unsigned NUM_CTL = 3;
  localparam int unsigned NUM_OUT = 4;
endpackage

// File: rtl/bus_term_sync.sv
module bus_term_sync #(
  parameter int unsigned WIDTH     = 3,
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= {WIDTH{RESET_VAL}};
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= {WIDTH{RESET_VAL}};
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bus_term_classify.sv
module bus_term_classify
  import bus_term_pkg::*;
(
  input  ctl_t     ctl_i,
  output logic     term_o,
  output outcome_e kind_o
);
  // error (alone or with halt) wins over acknowledge
  always_comb begin
    term_o = ctl_i.ack | ctl_i.err;
    if (ctl_i.err) kind_o = ctl_i.hlt ? OUT_RETRY : OUT_BERR;
    else           kind_o = ctl_i.hlt ? OUT_HALTED : OUT_NORMAL;
  end
endmodule

// File: rtl/bus_term_fsm.sv
module bus_term_fsm
  import bus_term_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cyc_start_i,
  input  logic               strobe_i,
  input  ctl_t               ctl_i,
  input  logic               term_i,
  input  outcome_e           kind_i,
  output logic [NUM_OUT-1:0] pulse_o,
  output logic               stall_o,
  output logic               retry_req_o
);
  state_e             state_q, state_d;
  outcome_e           kind_q, kind_d;
  logic [NUM_OUT-1:0] pulse_d;
  logic               rreq_d;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    pulse_d = '0;
    rreq_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cyc_start_i) state_d = ST_WAIT;
      ST_WAIT: begin
        // decision taken at state N, committed at N+2
        if (strobe_i && term_i) begin
          kind_d  = kind_i;
          state_d = ST_CONFIRM;
        end
      end
      ST_CONFIRM: begin
        if (strobe_i) begin
          pulse_d[kind_q] = 1'b1;
          state_d = (kind_q == OUT_HALTED || kind_q == OUT_RETRY) ? ST_HOLD : ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (!ctl_i.hlt) begin
          rreq_d  = (kind_q == OUT_RETRY);
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      kind_q      <= OUT_NORMAL;
      pulse_o     <= '0;
      retry_req_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      kind_q      <= kind_d;
      pulse_o     <= pulse_d;
      retry_req_o <= rreq_d;
    end
  end

  assign stall_o = (state_q == ST_HOLD);
endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
  import bus_term_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_start_i,
  input  logic even_state_i,
  input  logic dtack_ni,
  input  logic berr_ni,
  input  logic halt_ni,
  output logic normal_o,
  output logic halted_o,
  output logic bus_err_o,
  output logic retry_o,
  output logic stall_o,
  output logic retry_req_o
);
  logic [NUM_CTL-1:0] pins_n, sync_n;
  ctl_t               ctl;
  logic               term;
  outcome_e           kind;
  logic [NUM_OUT-1:0] pulse;

  assign pins_n = {dtack_ni, berr_ni, halt_ni};

  bus_term_sync #(
    .WIDTH    (NUM_CTL),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_n),
    .q_o   (sync_n)
  );

  assign ctl = ~sync_n;

  bus_term_classify i_classify (
    .ctl_i (ctl),
    .term_o(term),
    .kind_o(kind)
  );

  bus_term_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_start_i(cyc_start_i),
    .strobe_i   (even_state_i),
    .ctl_i      (ctl),
    .term_i     (term),
    .kind_i     (kind),
    .pulse_o    (pulse),
    .stall_o    (stall_o),
    .retry_req_o(retry_req_o)
  );

  assign normal_o  = pulse[OUT_NORMAL];
  assign halted_o  = pulse[OUT_HALTED];
  assign bus_err_o = pulse[OUT_BERR];
  assign retry_o   = pulse[OUT_RETRY];
endmodule

// File: rtl/bus_term_ctrl_chk.sv
module bus_term_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic even_state_i,
  input logic normal_o,
  input logic halted_o,
  input logic bus_err_o,
  input logic retry_o,
  input logic stall_o,
  input logic retry_req_o
);
  logic any_out;
  assign any_out = normal_o | halted_o | bus_err_o | retry_o;

  p_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({normal_o, halted_o, bus_err_o, retry_o}));

  p_one_clock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_out |=> !any_out);

  p_on_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_out |-> $past(even_state_i));

  p_stall_on_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o || retry_o) |-> stall_o);

  p_no_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    normal_o |-> !stall_o);

  p_no_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> !stall_o);

  p_rreq_at_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_req_o |-> (!stall_o && $past(stall_o)));

  p_rreq_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_req_o |=> !retry_req_o);
endmodule

bind bus_term_ctrl bus_term_ctrl_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .even_state_i(even_state_i),
  .normal_o    (normal_o),
  .halted_o    (halted_o),
  .bus_err_o   (bus_err_o),
  .retry_o     (retry_o),
  .stall_o     (stall_o),
  .retry_req_o (retry_req_o)
);

// File: tb/test_bus_term_ctrl.sv
`timescale 1ns/1ps
module test_bus_term_ctrl;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cyc_start_i = 1'b0;
  logic even_state_i = 1'b0;
  logic dtack_ni = 1'b1, berr_ni = 1'b1, halt_ni = 1'b1;
  logic normal_o, halted_o, bus_err_o, retry_o, stall_o, retry_req_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  bus_term_ctrl i_bus_term_ctrl (.*);

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  // reference model: pins seen two edges late, behavioural state
  logic [2:0] hist [$];
  int         m_st;
  int         m_kind;
  logic [5:0] exp_o;  // {rreq, stall, retry, berr, halted, normal}

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = {3'b111, 3'b111};
      m_st = 0; m_kind = 0; exp_o = '0;
    end else begin
      logic [2:0] seen;
      logic ack, err, hlt;
      seen = hist.pop_front();
      hist.push_back({dtack_ni, berr_ni, halt_ni});
      ack = !seen[2]; err = !seen[1]; hlt = !seen[0];
      exp_o = '0;
      case (m_st)
        0: if (cyc_start_i) m_st = 1;
        1: if (even_state_i && (ack || err)) begin
             m_kind = err ? (hlt ? 3 : 2) : (hlt ? 1 : 0);
             m_st = 2;
           end
        2: if (even_state_i) begin
             exp_o[m_kind] = 1'b1;
             m_st = (m_kind == 1 || m_kind == 3) ? 3 : 0;
           end
        default: if (!hlt) begin
             exp_o[5] = (m_kind == 3);
             m_st = 0;
           end
      endcase
      exp_o[4] = (m_st == 3);
    end
  end

  // per-cycle comparison, away from the active edge
  int cnt [6];
  always @(negedge clk_i) begin
    logic [5:0] act;
    string tags [6];
    tags = '{"R2", "R3", "R4", "R5", "R3", "R5"};
    act = {retry_req_o, stall_o, retry_o, bus_err_o, halted_o, normal_o};
    for (int i = 0; i < 6; i++) begin
      compared++;
      if (act[i] !== exp_o[i]) begin
        mismatched++;
        $display("FAIL %s cycle %0d output %0d actual=%b expected=%b", tags[i], cycles, i, act[i], exp_o[i]);
      end
      if (act[i] === 1'b1) cnt[i]++;
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles == 100000) begin
      mismatched++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(string tag, int act, int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 6; i++) cnt[i] = 0;
  endtask

  task automatic counts(string tag, int n, int h, int b, int r, int q);
    check({tag, " normal"}, cnt[0], n);
    check({tag, " halted"}, cnt[1], h);
    check({tag, " bus_err"}, cnt[2], b);
    check({tag, " retry"}, cnt[3], r);
    check({tag, " retry_req"}, cnt[5], q);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pins(logic [2:0] p);  // {dtack, berr, halt}, active low
    {dtack_ni, berr_ni, halt_ni} = p;
  endtask

  task automatic strobe();
    even_state_i = 1'b1; tick(1); even_state_i = 1'b0;
  endtask

  task automatic start();
    cyc_start_i = 1'b1; tick(1); cyc_start_i = 1'b0;
  endtask

  // waits: wait-state samples with pattern wp; then pn at N and p2 at N+2
  task automatic run(int waits, logic [2:0] wp, logic [2:0] pn, logic [2:0] p2);
    start();
    for (int w = 0; w < waits; w++) begin pins(wp); tick(3); strobe(); end
    pins(pn); tick(3); strobe();
    pins(p2); tick(3); strobe();
    tick(2);
  endtask

  task automatic release_halt();
    tick(4);
    pins(3'b111);
    tick(6);
  endtask

  initial begin
    tick(3);
    check("R1 reset stall", int'(stall_o), 0);
    check("R1 reset outcomes", int'({normal_o, halted_o, bus_err_o, retry_o, retry_req_o}), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    tick(1);
    check("R1 after reset", int'({normal_o, halted_o, bus_err_o, retry_o, stall_o, retry_req_o}), 0);

    // R10: strobes while idle do nothing
    clr(); pins(3'b011); tick(3); strobe(); tick(3); strobe(); tick(3); pins(3'b111); tick(3);
    counts("R10 idle strobe", 0, 0, 0, 0, 0);

    clr(); run(0, 3'b111, 3'b011, 3'b011); pins(3'b111); tick(3);
    counts("R2 normal", 1, 0, 0, 0, 0);
    check("R2 stall", int'(stall_o), 0);

    clr(); run(0, 3'b111, 3'b010, 3'b010);
    check("R3 stall held", int'(stall_o), 1);
    release_halt();
    check("R3 stall released", int'(stall_o), 0);
    counts("R3 halted", 0, 1, 0, 0, 0);

    clr(); run(0, 3'b111, 3'b101, 3'b101); pins(3'b111); tick(3);
    counts("R4 error alone", 0, 0, 1, 0, 0);
    clr(); run(0, 3'b111, 3'b001, 3'b001); pins(3'b111); tick(3);
    counts("R4 error with ack", 0, 0, 1, 0, 0);

    clr(); run(0, 3'b111, 3'b100, 3'b100);
    check("R5 stall held", int'(stall_o), 1);
    check("R5 no early request", cnt[5], 0);
    release_halt();
    counts("R5 retry", 0, 0, 0, 1, 1);
    check("R5 stall released", int'(stall_o), 0);

    clr(); run(0, 3'b111, 3'b011, 3'b001); pins(3'b111); tick(3);
    counts("R6 late error", 1, 0, 0, 0, 0);
    clr(); run(0, 3'b111, 3'b011, 3'b000); pins(3'b111); tick(6);
    counts("R6 late error and halt", 1, 0, 0, 0, 0);
    check("R6 stall", int'(stall_o), 0);

    clr(); run(3, 3'b111, 3'b011, 3'b011); pins(3'b111); tick(3);
    counts("R7 wait states", 1, 0, 0, 0, 0);
    clr(); run(2, 3'b110, 3'b010, 3'b010); release_halt();
    counts("R7 halt alone waits", 0, 1, 0, 0, 0);

    // R9: pin change one clock before a strobe is too late for it
    clr(); start(); pins(3'b111); tick(3);
    pins(3'b101); strobe(); tick(3);
    check("R9 not yet seen", cnt[2], 0);
    strobe(); tick(3);
    check("R9 sampled as N only", cnt[2], 0);
    strobe(); tick(2); pins(3'b111); tick(3);
    counts("R9 resolved", 0, 0, 1, 0, 0);

    // R10: cyc_start during a cycle does not restart or double it
    clr(); start(); pins(3'b011); tick(3); strobe();
    start(); tick(2); strobe(); tick(2); pins(3'b111); tick(3);
    strobe(); tick(3); strobe(); tick(3);
    counts("R10 mid-cycle start", 1, 0, 0, 0, 0);

    check("R8 final idle", int'(stall_o), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule